// File: doc/BRIEF.md
# Cache Line Zeroing Engine

This block carries out a zero-fill of one data cache line. A single command carries an effective address, the instruction word, the configured line size in bytes, a mode-control word with its enable, and the address currently held by the load-reservation tracker. The block works out the line size that applies, rounds the address down to the start of that line, and reports whether the reservation falls inside the line so that the tracker can drop it. It then writes the whole line as a run of 64-bit zero stores on a valid/ready store port.

The line size that applies is normally the configured one (32, 64 or 128 bytes). A narrow-line mode forces it to 32 bytes. This mode needs three things: the enable input high, bit 21 of the instruction word low, and the two-bit field at bits 8:7 of the mode word equal to 1. A command is taken only while the engine is idle. The engine stays busy until the final store of the line has been acknowledged.

Top module: `line_zero_engine`

## Requirements
- R1: The configured line size selects 4, 8 or 16 stores for 32, 64 or 128 bytes. Any other configured value behaves as 128 bytes (16 stores).
- R2: When `ovr_en` is high, `cmd_insn[21]` is 0 and `mode_word[8:7]` equals 2'b01, the line size is 32 bytes (4 stores), whatever size is configured.
- R3: If any one of those three conditions fails, the configured size of R1 applies.
- R4: The first store address is the command address with its low log2(line size) bits cleared.
- R5: Stores go to ascending addresses spaced 8 bytes apart, starting at the line base. Every store address is 8-byte aligned and every store carries all-zero data.
- R6: `resv_kill` is high in the accept cycle, and only then, when the reservation address masked to the line equals the aligned line base. This is combinational, so it occurs before any store is issued.
- R7: `busy` rises on accept and falls after the handshake of the last store. `cmd_ready` is low while busy, and a command offered while busy is ignored.
- R8: A store request that is not acknowledged stays valid at the same address.
- R9: After reset the engine is idle: `busy` is 0, `st_valid` is 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_addr | input | AW | Effective address to zero |
| cmd_insn | input | 32 | Instruction word; bit 21 blocks the narrow-line mode |
| line_bytes | input | 8 | Configured line size in bytes |
| ovr_en | input | 1 | Enables the narrow-line mode |
| mode_word | input | 32 | Mode control; bits 8:7 select the narrow line when equal to 1 |
| resv_addr | input | AW | Current load-reservation address |
| resv_kill | output | 1 | Reservation lies in the line being zeroed; invalidate it |
| st_valid | output | 1 | Store request valid |
| st_ready | input | 1 | Store request accepted |
| st_addr | output | AW | Store address |
| st_data | output | 64 | Store data (zero) |
| busy | output | 1 | Command in progress |

## Verification
The assertions check the port protocol on every cycle. A stalled store holds its address. An acknowledged store is followed by the next address 8 bytes on or by idle. Store addresses stay 8-byte aligned. An accepted command always sets busy. The reservation kill appears only in an accept cycle. Which line size applies, the aligned base, the exact number of stores, and whether the reservation matches can only be shown by the bench's scenarios, which compare them against values the bench computes itself. The same holds for the corner cases of unsupported configured sizes, reservations just inside and just outside the line, and each single failed condition of the narrow-line mode.

// File: rtl/line_zero_engine.sv
module line_zero_engine #(
  parameter int AW       = 32,
  parameter int MAX_LINE = 128,
  parameter int NARROW   = 32,
  parameter int INSN_BIT = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [31:0]   cmd_insn,
  input  logic [7:0]    line_bytes,
  input  logic          ovr_en,
  input  logic [31:0]   mode_word,
  input  logic [AW-1:0] resv_addr,
  output logic          resv_kill,
  output logic          st_valid,
  input  logic          st_ready,
  output logic [AW-1:0] st_addr,
  output logic [63:0]   st_data,
  output logic          busy
);
  localparam int BW     = $clog2(MAX_LINE / 8);
  localparam int LG_MAX = $clog2(MAX_LINE);
  localparam int LG_NAR = $clog2(NARROW);

  logic [2:0]    lg_cfg, lg_eff;
  logic          narrow, accept;
  logic [AW-1:0] mask, aligned, base_q;
  logic [BW:0]   n_beats;
  logic [BW-1:0] last_beat, idx_q, last_q;

  always_comb begin
    case (line_bytes)
      8'd32:   lg_cfg = 3'd5;
      8'd64:   lg_cfg = 3'd6;
      default: lg_cfg = 3'(LG_MAX);
    endcase
  end

  assign narrow    = ovr_en && !cmd_insn[INSN_BIT] && (mode_word[8:7] == 2'b01);
  assign lg_eff    = narrow ? 3'(LG_NAR) : lg_cfg;
  assign mask      = {AW{1'b1}} << lg_eff;
  assign aligned   = cmd_addr & mask;
  assign n_beats   = (BW+1)'(1) << (lg_eff - 3'd3);
  assign last_beat = BW'(n_beats - 1'b1);

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && !busy;
  assign resv_kill = accept && ((resv_addr & mask) == aligned);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      last_q <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      base_q <= aligned;
      idx_q  <= '0;
      last_q <= last_beat;
    end else if (busy && st_ready) begin
      if (idx_q == last_q) busy <= 1'b0;
      else                 idx_q <= idx_q + 1'b1;
    end
  end

  assign st_valid = busy;
  assign st_addr  = base_q + AW'({idx_q, 3'b000});
  assign st_data  = '0;
endmodule

// File: rtl/line_zero_engine_chk.sv
module line_zero_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          resv_kill,
  input logic          st_valid,
  input logic          st_ready,
  input logic [AW-1:0] st_addr,
  input logic          busy
);
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_addr)); // R8
  AST_NEXT_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready |=> !st_valid || (st_addr == $past(st_addr) + AW'(8))); // R5
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> st_addr[2:0] == 3'b000); // R5
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy); // R7
  AST_KILL_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    resv_kill |-> cmd_valid && cmd_ready); // R6
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready); // R7
endmodule

bind line_zero_engine line_zero_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .resv_kill(resv_kill), .st_valid(st_valid), .st_ready(st_ready),
  .st_addr(st_addr), .busy(busy)
);

// File: tb/sim_line_zero_engine.sv
module sim_line_zero_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_insn = '0;
  logic [7:0]  line_bytes = 8'd64;
  logic        ovr_en = 1'b0;
  logic [31:0] mode_word = '0;
  logic [31:0] resv_addr = '0;
  logic        resv_kill;
  logic        st_valid;
  logic        st_ready = 1'b0;
  logic [31:0] st_addr;
  logic [63:0] st_data;
  logic        busy;
  int vectors = 0;
  int errors  = 0;
  bit ended   = 0;

  always #5 clk = ~clk;

  line_zero_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_insn(cmd_insn), .line_bytes(line_bytes),
    .ovr_en(ovr_en), .mode_word(mode_word), .resv_addr(resv_addr),
    .resv_kill(resv_kill), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .busy(busy)
  );

  function automatic bit is_narrow(bit en, logic [31:0] insn, logic [31:0] mw);
    return en && !insn[21] && (mw[8:7] == 2'b01);
  endfunction

  function automatic int line_of(logic [7:0] lb, bit en, logic [31:0] insn, logic [31:0] mw);
    if (is_narrow(en, insn, mw)) return 32;
    if (lb == 8'd32) return 32;
    if (lb == 8'd64) return 64;
    return 128;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(logic [31:0] a, logic [31:0] insn, logic [7:0] lb,
                         bit en, logic [31:0] mw, logic [31:0] rv, int ready_pct);
    int size = line_of(lb, en, insn, mw);
    logic [31:0] base = a & ~(32'(size) - 1);
    bit kill = ((rv & ~(32'(size) - 1)) == base);
    string tag = is_narrow(en, insn, mw) ? "R2" : (en ? "R3" : "R1");
    int n = 0;
    int guard = 0;
    @(negedge clk);
    cmd_addr = a; cmd_insn = insn; line_bytes = lb; ovr_en = en;
    mode_word = mw; resv_addr = rv; cmd_valid = 1'b1;
    #1;
    chk(cmd_ready == 1'b1, "R7 ready when idle", longint'(cmd_ready), 1);
    chk(resv_kill == kill, "R6 reservation kill", longint'(resv_kill), longint'(kill));
    @(negedge clk);
    while (busy && guard < 400) begin
      guard++;
      cmd_valid = ($urandom % 3) == 0;
      cmd_addr  = $urandom;
      line_bytes = 8'd32;
      resv_addr = cmd_addr;
      st_ready  = ($urandom % 100) < ready_pct;
      #1;
      chk(cmd_ready == 1'b0 && resv_kill == 1'b0, "R7 busy blocks command",
          longint'({cmd_ready, resv_kill}), 0);
      chk(st_valid == 1'b1, "R8 store valid held", longint'(st_valid), 1);
      if (st_valid && st_ready) begin
        if (n == 0) chk(st_addr == base, "R4 aligned base", longint'(st_addr), longint'(base));
        else chk(st_addr == base + 32'(8 * n), "R5 store address", longint'(st_addr),
                 longint'(base + 32'(8 * n)));
        chk(st_data == 64'd0, "R5 zero data", longint'(st_data), 0);
        n++;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    st_ready  = 1'b0;
    chk(n == size / 8, tag, longint'(n), longint'(size / 8));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 1'b0 && st_valid == 1'b0 && cmd_ready == 1'b1, "R9 reset state",
        longint'({busy, st_valid, cmd_ready}), 1);
    rst_n = 1'b1;
    // R1 configured sizes and unsupported values
    run_cmd(32'h0000_1234, 32'h0, 8'd32,  1'b0, 32'h0, 32'hFFFF_FFF0, 100);
    run_cmd(32'h0000_1274, 32'h0, 8'd64,  1'b0, 32'h0, 32'hFFFF_FFF0, 100);
    run_cmd(32'h0000_12F4, 32'h0, 8'd128, 1'b0, 32'h0, 32'hFFFF_FFF0, 60);
    run_cmd(32'h0000_5555, 32'h0, 8'd0,   1'b0, 32'h0, 32'h0, 60);
    run_cmd(32'h0000_5555, 32'h0, 8'd96,  1'b0, 32'h0, 32'h0, 60);
    // R2 narrow line forced
    run_cmd(32'hABCD_EF7F, 32'h0, 8'd128, 1'b1, 32'h0000_0080, 32'hABCD_EF60, 50);
    // R3 each narrow condition failing alone
    run_cmd(32'hABCD_EF7F, 32'h0020_0000, 8'd128, 1'b1, 32'h0000_0080, 32'h0, 50);
    run_cmd(32'hABCD_EF7F, 32'h0, 8'd64, 1'b1, 32'h0000_0100, 32'h0, 50);
    run_cmd(32'hABCD_EF7F, 32'h0, 8'd64, 1'b0, 32'h0000_0080, 32'h0, 50);
    // R6 reservation inside, at the edge, just outside
    run_cmd(32'h0000_2040, 32'h0, 8'd64, 1'b0, 32'h0, 32'h0000_207F, 100);
    run_cmd(32'h0000_2040, 32'h0, 8'd64, 1'b0, 32'h0, 32'h0000_2080, 100);
    run_cmd(32'h0000_2040, 32'h0, 8'd64, 1'b0, 32'h0, 32'h0000_203F, 100);
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a = $urandom;
      logic [7:0]  lb;
      logic [31:0] mw = $urandom;
      logic [31:0] rv;
      case ($urandom % 4)
        0: lb = 8'd32;
        1: lb = 8'd64;
        2: lb = 8'd128;
        default: lb = 8'($urandom);
      endcase
      if ($urandom % 2) mw[8:7] = 2'b01;
      rv = ($urandom % 2) ? (a ^ 32'($urandom % 32)) : $urandom;
      run_cmd(a, $urandom, lb, 1'($urandom), mw, rv, 30 + int'($urandom % 71));
    end
    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule